// File: doc/BRIEF.md
# Load/Store Address Generator with Base Writeback

This block works out memory addresses for load and store instructions, together with the value to write back into the base register. It has two independent paths.

The single-transfer path takes a base value and an offset. The offset is an immediate, a register, or a register shifted by a constant amount. It is added to or subtracted from the base. The path then applies pre-indexing or post-indexing and decides whether the base is updated. It checks natural alignment and refuses an illegal operand. Its result is registered and appears one cycle after the request.

The block-transfer path takes a base, a 16-bit register mask and a stepping mode. It then emits one word address per cycle. Each beat carries the register index it belongs to. The final beat is marked, and the updated base value is presented with it.

A base that names the program counter is corrected by the pipeline offset of 8 bytes, so the caller passes the raw instruction address. Memory and register-file access are left to the surrounding pipeline, which consumes the strobes.

Top module: `lsagu`

## Requirements
- R1: An immediate offset is zero-extended. Its width is 12 bits for size codes 0 (byte) and 2 (word), and only the low 8 bits for size codes 1 (halfword) and 3 (signed byte), so that immediate bits 11:8 are ignored for those codes. sg_up=1 adds the offset and sg_up=0 subtracts it.
- R2: Offset kind 1 uses the offset register as it is. Kind 2 uses it shifted by sg_sha bits: shift code 0 is a logical left shift, 1 a logical right shift, 2 an arithmetic right shift and 3 a rotate right. Kind 0 selects the immediate.
- R3: With sg_pre=1, the address is base±offset. Write-back is enabled exactly when sg_wb=1, and the write-back value is that same address.
- R4: With sg_pre=0, the address is the unmodified base. Write-back is always enabled, with the value base±offset.
- R5: When sg_base_pc=1, the base used for both address and write-back is sg_base+8.
- R6: A register offset (kind 1 or 2) taken from the program counter (sg_oreg_pc=1) raises sg_illegal. It also clears sg_acc and sg_wb_en.
- R7: A word access (size 2) whose address has bits 1:0 not equal to zero faults. So does a halfword access (size 1) whose address has bit 0 set. Byte sizes never fault. A fault raises sg_align_fault and clears sg_acc and sg_wb_en.
- R8: sg_done is high for exactly the one cycle after a cycle with sg_req=1, and the single-path outputs are valid in that cycle.
- R9: After bk_start, the first beat appears in the next cycle, and one beat follows per cycle. Beats run in ascending register order, each address is 4 above the previous one, and bk_last marks the final beat.
- R10: The first beat address is base for mode 0 (increment after), base+4 for mode 1 (increment before), base-4N+4 for mode 2 (decrement after) and base-4N for mode 3 (decrement before). Here N is the number of set bits in the mask.
- R11: bk_done is high with the final beat. It carries bk_wb_val = base+4N for modes 0 and 1 and base-4N for modes 2 and 3, with bk_wb_en equal to the bk_wb captured at start.
- R12: An empty mask produces no beats. bk_done is high in the next cycle with bk_wb_val = base and bk_wb_en = bk_wb.
- R13: A block base with bits 1:0 not equal to zero produces no beats. In the next cycle it raises bk_fault and bk_done, with bk_wb_en low.
- R14: bk_start while a block transfer is in progress is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sg_req | input | 1 | Single-transfer request |
| sg_base | input | 32 | Base register value |
| sg_base_pc | input | 1 | Base is the program counter |
| sg_imm | input | 12 | Immediate offset |
| sg_oreg | input | 32 | Offset register value |
| sg_oreg_pc | input | 1 | Offset register is the program counter |
| sg_okind | input | 2 | Offset kind: 0 immediate, 1 register, 2 shifted register |
| sg_shk | input | 2 | Shift code |
| sg_sha | input | 5 | Shift amount |
| sg_up | input | 1 | 1 add offset, 0 subtract |
| sg_pre | input | 1 | 1 pre-indexed, 0 post-indexed |
| sg_wb | input | 1 | Write-back request for pre-indexed form |
| sg_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 signed byte |
| sg_done | output | 1 | Single result valid |
| sg_acc | output | 1 | Access permitted |
| sg_addr | output | 32 | Effective address |
| sg_wb_en | output | 1 | Base write-back enable |
| sg_wb_val | output | 32 | Base write-back value |
| sg_align_fault | output | 1 | Misaligned address |
| sg_illegal | output | 1 | Illegal offset operand |
| bk_start | input | 1 | Start block transfer |
| bk_base | input | 32 | Block base value |
| bk_list | input | 16 | Register mask |
| bk_mode | input | 2 | Stepping mode 0..3 |
| bk_wb | input | 1 | Block write-back request |
| bk_valid | output | 1 | Beat valid |
| bk_addr | output | 32 | Beat word address |
| bk_reg | output | 4 | Beat register index |
| bk_last | output | 1 | Final beat |
| bk_done | output | 1 | Block transfer complete |
| bk_wb_en | output | 1 | Block write-back enable |
| bk_wb_val | output | 32 | Block write-back value |
| bk_fault | output | 1 | Block base misaligned |

## Verification
The assertions assume that requests are sampled only at clock edges while reset is low. They also assume that a start pulse given during a running block sequence must leave the beat stream intact. The step and ordering checks therefore hold for any mask. The stimulus changes inputs only on the falling edge and holds each request for exactly one cycle. It deliberately repeats a start inside a running sequence, so that the ignore rule is exercised within that assumption rather than around it.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;
    localparam int PC_AHEAD   = 8;
    localparam int WORD_BYTES = 4;

    typedef enum logic [1:0] {
        OK_IMM    = 2'd0,
        OK_REG    = 2'd1,
        OK_SCALED = 2'd2,
        OK_RSVD   = 2'd3
    } okind_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shk_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_SBYTE = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        BK_INC_AFTER  = 2'd0,
        BK_INC_BEFORE = 2'd1,
        BK_DEC_AFTER  = 2'd2,
        BK_DEC_BEFORE = 2'd3
    } bkmode_e;

    function automatic logic narrow_imm(size_e sz);
        return (sz == SZ_HALF) || (sz == SZ_SBYTE);
    endfunction
endpackage

// File: rtl/lsagu_offset.sv
module lsagu_offset
    import lsagu_pkg::*;
#(
    parameter int AW     = 32,
    parameter int IMM_W  = 12,
    parameter int NIMM_W = 8,
    localparam int SHW   = $clog2(AW)
) (
    input  logic [IMM_W-1:0] imm,
    input  logic             narrow,
    input  logic [AW-1:0]    oreg,
    input  okind_e           kind,
    input  shk_e             shk,
    input  logic [SHW-1:0]   sha,
    output logic [AW-1:0]    off
);
    logic [AW-1:0] shifted;
    logic [AW-1:0] imm_ext;

    always_comb begin
        unique case (shk)
            SH_LSL: shifted = oreg << sha;
            SH_LSR: shifted = oreg >> sha;
            SH_ASR: shifted = AW'($signed(oreg) >>> sha);
            default: shifted = (sha == '0) ? oreg
                             : ((oreg >> sha) | (oreg << (AW - int'(sha))));
        endcase
    end

    always_comb begin
        if (narrow) imm_ext = AW'(imm[NIMM_W-1:0]);
        else        imm_ext = AW'(imm);
    end

    always_comb begin
        unique case (kind)
            OK_REG:    off = oreg;
            OK_SCALED: off = shifted;
            default:   off = imm_ext;
        endcase
    end
endmodule

// File: rtl/lsagu_single.sv
module lsagu_single
    import lsagu_pkg::*;
#(
    parameter int AW     = 32,
    parameter int IMM_W  = 12,
    parameter int NIMM_W = 8,
    localparam int SHW   = $clog2(AW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [AW-1:0]    base,
    input  logic             base_pc,
    input  logic [IMM_W-1:0] imm,
    input  logic [AW-1:0]    oreg,
    input  logic             oreg_pc,
    input  okind_e           kind,
    input  shk_e             shk,
    input  logic [SHW-1:0]   sha,
    input  logic             up,
    input  logic             pre,
    input  logic             wb,
    input  size_e            size,
    output logic             done,
    output logic             acc,
    output logic [AW-1:0]    addr,
    output logic             wb_en,
    output logic [AW-1:0]    wb_val,
    output logic             align_fault,
    output logic             illegal
);
    logic [AW-1:0] off, base_eff, sum, ea;
    logic          flt, ill;

    lsagu_offset #(.AW(AW), .IMM_W(IMM_W), .NIMM_W(NIMM_W)) u_off (
        .imm    (imm),
        .narrow (narrow_imm(size)),
        .oreg   (oreg),
        .kind   (kind),
        .shk    (shk),
        .sha    (sha),
        .off    (off)
    );

    always_comb begin
        base_eff = base_pc ? base + AW'(PC_AHEAD) : base;
        sum      = up ? base_eff + off : base_eff - off;
        ea       = pre ? sum : base_eff;
        ill      = oreg_pc && (kind == OK_REG || kind == OK_SCALED);
        unique case (size)
            SZ_WORD: flt = (ea[1:0] != 2'b00);
            SZ_HALF: flt = ea[0];
            default: flt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done        <= 1'b0;
            acc         <= 1'b0;
            addr        <= '0;
            wb_en       <= 1'b0;
            wb_val      <= '0;
            align_fault <= 1'b0;
            illegal     <= 1'b0;
        end else begin
            done <= req;
            if (req) begin
                addr        <= ea;
                wb_val      <= sum;
                align_fault <= flt;
                illegal     <= ill;
                acc         <= !flt && !ill;
                wb_en       <= (!pre || wb) && !flt && !ill;
            end
        end
    end

    // R8: a result only appears in the cycle after a request
    a_r8_done_after_req: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(req));

    // R7: a fault blocks both the access and the base update
    a_r7_fault_suppress: assert property (@(posedge clk) disable iff (rst)
        (done && align_fault) |-> (!acc && !wb_en));

    // R6: an illegal operand blocks both the access and the base update
    a_r6_illegal_suppress: assert property (@(posedge clk) disable iff (rst)
        (done && illegal) |-> (!acc && !wb_en));
endmodule

// File: rtl/lsagu_block.sv
module lsagu_block
    import lsagu_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LIST_W = 16,
    localparam int IDXW  = $clog2(LIST_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     base,
    input  logic [LIST_W-1:0] list,
    input  bkmode_e           mode,
    input  logic              wb,
    output logic              valid,
    output logic [AW-1:0]     addr,
    output logic [IDXW-1:0]   reg_idx,
    output logic              last,
    output logic              done,
    output logic              wb_en,
    output logic [AW-1:0]     wb_val,
    output logic              fault
);
    logic              busy, wbf, edone, eflt;
    logic [LIST_W-1:0] pend;
    logic [AW-1:0]     cur, fin;
    logic [IDXW:0]     cnt;
    logic [AW-1:0]     span, first_addr, final_val;
    logic [IDXW-1:0]   low_idx;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < LIST_W; i++) cnt = cnt + (IDXW+1)'(list[i]);
    end

    always_comb begin
        low_idx = '0;
        for (int i = LIST_W - 1; i >= 0; i--) begin
            if (pend[i]) low_idx = IDXW'(i);
        end
    end

    always_comb begin
        span = AW'(cnt) * AW'(WORD_BYTES);
        unique case (mode)
            BK_INC_AFTER:  first_addr = base;
            BK_INC_BEFORE: first_addr = base + AW'(WORD_BYTES);
            BK_DEC_AFTER:  first_addr = base - span + AW'(WORD_BYTES);
            default:       first_addr = base - span;
        endcase
        final_val = (mode == BK_INC_AFTER || mode == BK_INC_BEFORE) ? base + span
                                                                      : base - span;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            wbf   <= 1'b0;
            edone <= 1'b0;
            eflt  <= 1'b0;
            pend  <= '0;
            cur   <= '0;
            fin   <= '0;
        end else begin
            edone <= 1'b0;
            eflt  <= 1'b0;
            if (busy) begin
                pend <= pend & (pend - LIST_W'(1));
                cur  <= cur + AW'(WORD_BYTES);
                if (last) busy <= 1'b0;
            end else if (start) begin
                wbf <= wb;
                fin <= final_val;
                if (base[1:0] != 2'b00) begin
                    eflt  <= 1'b1;
                    edone <= 1'b1;
                end else if (list == '0) begin
                    edone <= 1'b1;
                end else begin
                    busy <= 1'b1;
                    pend <= list;
                    cur  <= first_addr;
                end
            end
        end
    end

    assign valid   = busy;
    assign addr    = cur;
    assign reg_idx = low_idx;
    assign last    = busy && ((pend & (pend - LIST_W'(1))) == '0);
    assign done    = (busy && last) || edone;
    assign fault   = eflt;
    assign wb_en   = done && wbf && !eflt;
    assign wb_val  = fin;

    // R9: consecutive beats step by one word
    a_r9_addr_step: assert property (@(posedge clk) disable iff (rst)
        (valid && !last) |=> (valid && addr == $past(addr) + AW'(WORD_BYTES)));

    // R9: register indices rise strictly across a sequence
    a_r9_reg_rise: assert property (@(posedge clk) disable iff (rst)
        (valid && !last) |=> (reg_idx > $past(reg_idx)));

    // R11: the final beat carries completion
    a_r11_last_done: assert property (@(posedge clk) disable iff (rst)
        (valid && last) |-> done);

    // R13: a faulting start never produces a beat
    a_r13_fault_no_beat: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!valid && done && !wb_en));
endmodule

// File: rtl/lsagu.sv
module lsagu
    import lsagu_pkg::*;
#(
    parameter int AW     = 32,
    parameter int IMM_W  = 12,
    parameter int NIMM_W = 8,
    parameter int LIST_W = 16,
    localparam int SHW   = $clog2(AW),
    localparam int IDXW  = $clog2(LIST_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sg_req,
    input  logic [AW-1:0]     sg_base,
    input  logic              sg_base_pc,
    input  logic [IMM_W-1:0]  sg_imm,
    input  logic [AW-1:0]     sg_oreg,
    input  logic              sg_oreg_pc,
    input  logic [1:0]        sg_okind,
    input  logic [1:0]        sg_shk,
    input  logic [SHW-1:0]    sg_sha,
    input  logic              sg_up,
    input  logic              sg_pre,
    input  logic              sg_wb,
    input  logic [1:0]        sg_size,
    output logic              sg_done,
    output logic              sg_acc,
    output logic [AW-1:0]     sg_addr,
    output logic              sg_wb_en,
    output logic [AW-1:0]     sg_wb_val,
    output logic              sg_align_fault,
    output logic              sg_illegal,
    input  logic              bk_start,
    input  logic [AW-1:0]     bk_base,
    input  logic [LIST_W-1:0] bk_list,
    input  logic [1:0]        bk_mode,
    input  logic              bk_wb,
    output logic              bk_valid,
    output logic [AW-1:0]     bk_addr,
    output logic [IDXW-1:0]   bk_reg,
    output logic              bk_last,
    output logic              bk_done,
    output logic              bk_wb_en,
    output logic [AW-1:0]     bk_wb_val,
    output logic              bk_fault
);
    lsagu_single #(.AW(AW), .IMM_W(IMM_W), .NIMM_W(NIMM_W)) u_single (
        .clk         (clk),
        .rst         (rst),
        .req         (sg_req),
        .base        (sg_base),
        .base_pc     (sg_base_pc),
        .imm         (sg_imm),
        .oreg        (sg_oreg),
        .oreg_pc     (sg_oreg_pc),
        .kind        (okind_e'(sg_okind)),
        .shk         (shk_e'(sg_shk)),
        .sha         (sg_sha),
        .up          (sg_up),
        .pre         (sg_pre),
        .wb          (sg_wb),
        .size        (size_e'(sg_size)),
        .done        (sg_done),
        .acc         (sg_acc),
        .addr        (sg_addr),
        .wb_en       (sg_wb_en),
        .wb_val      (sg_wb_val),
        .align_fault (sg_align_fault),
        .illegal     (sg_illegal)
    );

    lsagu_block #(.AW(AW), .LIST_W(LIST_W)) u_block (
        .clk     (clk),
        .rst     (rst),
        .start   (bk_start),
        .base    (bk_base),
        .list    (bk_list),
        .mode    (bkmode_e'(bk_mode)),
        .wb      (bk_wb),
        .valid   (bk_valid),
        .addr    (bk_addr),
        .reg_idx (bk_reg),
        .last    (bk_last),
        .done    (bk_done),
        .wb_en   (bk_wb_en),
        .wb_val  (bk_wb_val),
        .fault   (bk_fault)
    );
endmodule

// File: tb/test_lsagu.sv
module test_lsagu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sg_req = 1'b0;
    logic [31:0] sg_base = '0;
    logic        sg_base_pc = 1'b0;
    logic [11:0] sg_imm = '0;
    logic [31:0] sg_oreg = '0;
    logic        sg_oreg_pc = 1'b0;
    logic [1:0]  sg_okind = '0;
    logic [1:0]  sg_shk = '0;
    logic [4:0]  sg_sha = '0;
    logic        sg_up = 1'b0;
    logic        sg_pre = 1'b0;
    logic        sg_wb = 1'b0;
    logic [1:0]  sg_size = '0;
    logic        sg_done, sg_acc, sg_wb_en, sg_align_fault, sg_illegal;
    logic [31:0] sg_addr, sg_wb_val;
    logic        bk_start = 1'b0;
    logic [31:0] bk_base = '0;
    logic [15:0] bk_list = '0;
    logic [1:0]  bk_mode = '0;
    logic        bk_wb = 1'b0;
    logic        bk_valid, bk_last, bk_done, bk_wb_en, bk_fault;
    logic [31:0] bk_addr, bk_wb_val;
    logic [3:0]  bk_reg;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lsagu i_lsagu (
        .clk(clk), .rst(rst),
        .sg_req(sg_req), .sg_base(sg_base), .sg_base_pc(sg_base_pc), .sg_imm(sg_imm),
        .sg_oreg(sg_oreg), .sg_oreg_pc(sg_oreg_pc), .sg_okind(sg_okind), .sg_shk(sg_shk),
        .sg_sha(sg_sha), .sg_up(sg_up), .sg_pre(sg_pre), .sg_wb(sg_wb), .sg_size(sg_size),
        .sg_done(sg_done), .sg_acc(sg_acc), .sg_addr(sg_addr), .sg_wb_en(sg_wb_en),
        .sg_wb_val(sg_wb_val), .sg_align_fault(sg_align_fault), .sg_illegal(sg_illegal),
        .bk_start(bk_start), .bk_base(bk_base), .bk_list(bk_list), .bk_mode(bk_mode),
        .bk_wb(bk_wb), .bk_valid(bk_valid), .bk_addr(bk_addr), .bk_reg(bk_reg),
        .bk_last(bk_last), .bk_done(bk_done), .bk_wb_en(bk_wb_en), .bk_wb_val(bk_wb_val),
        .bk_fault(bk_fault)
    );

    typedef struct packed {
        logic [7:0]  tag;
        logic [31:0] base;
        logic        bpc;
        logic [11:0] imm;
        logic [31:0] oreg;
        logic        opc;
        logic [1:0]  kind;
        logic [1:0]  shk;
        logic [4:0]  sha;
        logic        up;
        logic        pre;
        logic        wb;
        logic [1:0]  size;
        logic [31:0] e_addr;
        logic        e_wbe;
        logic [31:0] e_wbv;
        logic        e_flt;
        logic        e_ill;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        // R1 word, 12-bit immediate, add, pre, no write-back
        '{8'd1, 32'h1000, 1'b0, 12'h124, 32'h0, 1'b0, 2'd0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 2'd2, 32'h1124, 1'b0, 32'h1124, 1'b0, 1'b0},
        // R3 subtract, pre with write-back
        '{8'd3, 32'h1000, 1'b0, 12'h010, 32'h0, 1'b0, 2'd0, 2'd0, 5'd0, 1'b0, 1'b1, 1'b1, 2'd2, 32'h0FF0, 1'b1, 32'h0FF0, 1'b0, 1'b0},
        // R1 halfword keeps only 8 immediate bits
        '{8'd1, 32'h2000, 1'b0, 12'hF06, 32'h0, 1'b0, 2'd0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 2'd1, 32'h2006, 1'b0, 32'h2006, 1'b0, 1'b0},
        // R1 byte uses all 12 immediate bits
        '{8'd1, 32'h2000, 1'b0, 12'hF05, 32'h0, 1'b0, 2'd0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 2'd0, 32'h2F05, 1'b0, 32'h2F05, 1'b0, 1'b0},
        // R2 plain register, subtract, write-back
        '{8'd2, 32'h3000, 1'b0, 12'h0, 32'h40, 1'b0, 2'd1, 2'd0, 5'd0, 1'b0, 1'b1, 1'b1, 2'd2, 32'h2FC0, 1'b1, 32'h2FC0, 1'b0, 1'b0},
        // R2 shift left 2
        '{8'd2, 32'h3000, 1'b0, 12'h0, 32'h10, 1'b0, 2'd2, 2'd0, 5'd2, 1'b1, 1'b1, 1'b0, 2'd2, 32'h3040, 1'b0, 32'h3040, 1'b0, 1'b0},
        // R2 logical right 4
        '{8'd2, 32'h3000, 1'b0, 12'h0, 32'h800, 1'b0, 2'd2, 2'd1, 5'd4, 1'b0, 1'b1, 1'b0, 2'd0, 32'h2F80, 1'b0, 32'h2F80, 1'b0, 1'b0},
        // R2 arithmetic right 4
        '{8'd2, 32'h3000, 1'b0, 12'h0, 32'hFFFFFF00, 1'b0, 2'd2, 2'd2, 5'd4, 1'b1, 1'b1, 1'b0, 2'd2, 32'h2FF0, 1'b0, 32'h2FF0, 1'b0, 1'b0},
        // R2 rotate right 8
        '{8'd2, 32'h3000, 1'b0, 12'h0, 32'h100, 1'b0, 2'd2, 2'd3, 5'd8, 1'b1, 1'b1, 1'b0, 2'd0, 32'h3001, 1'b0, 32'h3001, 1'b0, 1'b0},
        // R4 post-index, immediate
        '{8'd4, 32'h4000, 1'b0, 12'h008, 32'h0, 1'b0, 2'd0, 2'd0, 5'd0, 1'b1, 1'b0, 1'b0, 2'd2, 32'h4000, 1'b1, 32'h4008, 1'b0, 1'b0},
        // R4 post-index, register subtract
        '{8'd4, 32'h4000, 1'b0, 12'h0, 32'h20, 1'b0, 2'd1, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 2'd2, 32'h4000, 1'b1, 32'h3FE0, 1'b0, 1'b0},
        // R5 program-counter base, pre
        '{8'd5, 32'h0100, 1'b1, 12'h004, 32'h0, 1'b0, 2'd0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 2'd2, 32'h010C, 1'b0, 32'h010C, 1'b0, 1'b0},
        // R5 program-counter base, post
        '{8'd5, 32'h0100, 1'b1, 12'h000, 32'h0, 1'b0, 2'd0, 2'd0, 5'd0, 1'b1, 1'b0, 1'b0, 2'd2, 32'h0108, 1'b1, 32'h0108, 1'b0, 1'b0},
        // R6 offset register is the program counter
        '{8'd6, 32'h5000, 1'b0, 12'h0, 32'h4, 1'b1, 2'd1, 2'd0, 5'd0, 1'b1, 1'b1, 1'b1, 2'd2, 32'h5004, 1'b0, 32'h5004, 1'b0, 1'b1},
        // R7 misaligned word
        '{8'd7, 32'h6002, 1'b0, 12'h0, 32'h0, 1'b0, 2'd0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b1, 2'd2, 32'h6002, 1'b0, 32'h6002, 1'b1, 1'b0},
        // R7 misaligned halfword
        '{8'd7, 32'h6001, 1'b0, 12'h0, 32'h0, 1'b0, 2'd0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 2'd1, 32'h6001, 1'b0, 32'h6001, 1'b1, 1'b0},
        // R7 aligned halfword
        '{8'd7, 32'h6002, 1'b0, 12'h0, 32'h0, 1'b0, 2'd0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 2'd1, 32'h6002, 1'b0, 32'h6002, 1'b0, 1'b0},
        // R7 signed byte at an odd address
        '{8'd7, 32'h6001, 1'b0, 12'hF02, 32'h0, 1'b0, 2'd0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 2'd3, 32'h6003, 1'b0, 32'h6003, 1'b0, 1'b0},
        // R7 post-index fault suppresses write-back
        '{8'd7, 32'h6001, 1'b0, 12'h004, 32'h0, 1'b0, 2'd0, 2'd0, 5'd0, 1'b1, 1'b0, 1'b0, 2'd2, 32'h6001, 1'b0, 32'h6005, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    task automatic run_block(input logic [31:0] base, input logic [15:0] list,
                             input logic [1:0] mode, input logic wb);
        int n = 0;
        int seen = 0;
        logic [31:0] a, fin;
        for (int i = 0; i < 16; i++) n += int'(list[i]);
        case (mode)
            2'd0: a = base;
            2'd1: a = base + 32'd4;
            2'd2: a = base - 32'(4 * n) + 32'd4;
            default: a = base - 32'(4 * n);
        endcase
        fin = (mode < 2'd2) ? base + 32'(4 * n) : base - 32'(4 * n);
        bk_base = base; bk_list = list; bk_mode = mode; bk_wb = wb; bk_start = 1'b1;
        @(negedge clk);
        bk_start = 1'b0;
        if (base[1:0] != 2'b00) begin
            // R13 misaligned base
            chk("R13", "fault", 32'(bk_fault), 32'd1);
            chk("R13", "done", 32'(bk_done), 32'd1);
            chk("R13", "valid", 32'(bk_valid), 32'd0);
            chk("R13", "wb_en", 32'(bk_wb_en), 32'd0);
        end else if (list == 16'h0) begin
            // R12 empty mask
            chk("R12", "done", 32'(bk_done), 32'd1);
            chk("R12", "valid", 32'(bk_valid), 32'd0);
            chk("R12", "wb_val", bk_wb_val, base);
            chk("R12", "wb_en", 32'(bk_wb_en), 32'(wb));
        end else begin
            for (int i = 0; i < 16; i++) begin
                if (list[i]) begin
                    seen++;
                    chk("R9", "valid", 32'(bk_valid), 32'd1);
                    chk("R9", "reg", 32'(bk_reg), 32'(i));
                    chk("R10", "addr", bk_addr, a);
                    chk("R9", "last", 32'(bk_last), 32'(seen == n));
                    if (seen == n) begin
                        chk("R11", "done", 32'(bk_done), 32'd1);
                        chk("R11", "wb_val", bk_wb_val, fin);
                        chk("R11", "wb_en", 32'(bk_wb_en), 32'(wb));
                    end else begin
                        chk("R11", "early done", 32'(bk_done), 32'd0);
                    end
                    a = a + 32'd4;
                    @(negedge clk);
                end
            end
        end
        if (base[1:0] != 2'b00 || list == 16'h0) @(negedge clk);
        chk("R9", "idle valid", 32'(bk_valid), 32'd0);
        chk("R9", "idle done", 32'(bk_done), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R8: act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        chk("R8", "reset sg_done", 32'(sg_done), 32'd0);
        chk("R9", "reset bk_valid", 32'(bk_valid), 32'd0);
        chk("R12", "reset bk_done", 32'(bk_done), 32'd0);
        chk("R13", "reset bk_fault", 32'(bk_fault), 32'd0);

        for (int i = 0; i < NV; i++) begin
            automatic vec_t v = VEC[i];
            automatic string t = $sformatf("R%0d", v.tag);
            sg_base = v.base; sg_base_pc = v.bpc; sg_imm = v.imm; sg_oreg = v.oreg;
            sg_oreg_pc = v.opc; sg_okind = v.kind; sg_shk = v.shk; sg_sha = v.sha;
            sg_up = v.up; sg_pre = v.pre; sg_wb = v.wb; sg_size = v.size; sg_req = 1'b1;
            @(negedge clk);
            sg_req = 1'b0;
            chk("R8", "done", 32'(sg_done), 32'd1);
            chk(t, "addr", sg_addr, v.e_addr);
            chk(t, "wb_en", 32'(sg_wb_en), 32'(v.e_wbe));
            chk(t, "wb_val", sg_wb_val, v.e_wbv);
            chk(t, "fault", 32'(sg_align_fault), 32'(v.e_flt));
            chk(t, "illegal", 32'(sg_illegal), 32'(v.e_ill));
            chk(t, "acc", 32'(sg_acc), 32'(!v.e_flt && !v.e_ill));
        end
        @(negedge clk);
        // R8 done is a single-cycle pulse
        chk("R8", "done drops", 32'(sg_done), 32'd0);

        run_block(32'h8000, 16'h0085, 2'd0, 1'b1);   // R10 increment after
        run_block(32'h8000, 16'h8001, 2'd1, 1'b1);   // R10 increment before
        run_block(32'h8000, 16'h0070, 2'd2, 1'b1);   // R10 decrement after
        run_block(32'h8000, 16'h0003, 2'd3, 1'b0);   // R10 decrement before, R11 no write-back
        run_block(32'h8100, 16'h0400, 2'd0, 1'b1);   // R9 single beat
        run_block(32'h9000, 16'hFFFF, 2'd0, 1'b1);   // R11 full mask
        run_block(32'h9000, 16'hFFFF, 2'd3, 1'b1);   // R11 full mask decrement
        run_block(32'h7000, 16'h0000, 2'd2, 1'b1);   // R12 empty mask
        run_block(32'h8002, 16'h0003, 2'd0, 1'b1);   // R13 misaligned base

        // R14 start during a running sequence is ignored
        bk_base = 32'h9000; bk_list = 16'h0007; bk_mode = 2'd0; bk_wb = 1'b1; bk_start = 1'b1;
        @(negedge clk);
        chk("R14", "beat0 addr", bk_addr, 32'h9000);
        bk_base = 32'hA000; bk_list = 16'h0001; bk_mode = 2'd3; bk_wb = 1'b0; bk_start = 1'b1;
        @(negedge clk);
        bk_start = 1'b0;
        chk("R14", "beat1 reg", 32'(bk_reg), 32'd1);
        chk("R14", "beat1 addr", bk_addr, 32'h9004);
        @(negedge clk);
        chk("R14", "beat2 addr", bk_addr, 32'h9008);
        chk("R14", "beat2 last", 32'(bk_last), 32'd1);
        chk("R14", "wb_val", bk_wb_val, 32'h900C);
        chk("R14", "wb_en", 32'(bk_wb_en), 32'd1);
        @(negedge clk);
        chk("R14", "no restart", 32'(bk_valid), 32'd0);
        chk("R14", "no extra done", 32'(bk_done), 32'd0);

        finish_run();
    end
endmodule